// File: doc/BRIEF.md
# Two-Port GPIO Expander with I2C Target Interface

This block is an I2C target that gives a host controller sixteen general-purpose pins, grouped as two 8-bit ports. Each pin has four register bits: a sampled input value, an output value, a polarity bit that inverts the sampled value seen by the host, and a direction bit that switches the pin driver on or off. The host reaches these bits through ordinary I2C transfers. It writes a command byte that selects a register, then writes or reads data bytes. On each further byte the register pointer alternates between the port 0 and port 1 halves of the selected pair.

The bus side takes the synchronised levels of SCL and SDA and drives SDA through an open-drain enable. The low bits of the target address come from a select input, which is captured at each start condition. All logic runs on one system clock that oversamples the bus. An SCL phase must therefore last several system clock cycles.

Top module: `gpx_expander`

## Requirements
- R1: A falling SDA while SCL is high is a start. It restarts address reception from any state, including partway through a byte. A rising SDA while SCL is high is a stop. It releases SDA and leaves the block idle.
- R2: After a start, eight bits are shifted in MSB first: a 7-bit address, then the read/write bit (1 = read). On a match, the target holds SDA low through the whole high phase of the ninth clock. On a mismatch it never pulls SDA low, and it ignores bytes until the next start.
- R3: The target address is the upper 7-SEL_W bits of ADDR_BASE joined to `addr_sel_i`. The select value is captured at the start condition, so a later change inside the transaction has no effect.
- R4: The first byte of a write is a command byte. Its bits [2:1] pick the register group (0 input, 1 output, 2 polarity, 3 direction) and bit 0 picks the port. Each data byte written or read after it flips the port bit. The target acknowledges the command byte and every written data byte.
- R5: Data bytes written while the pointer is in the input group change no register.
- R6: A direction bit of 1 makes the pin an input: `pin_oe_o` is low for that pin. A direction bit of 0 drives the pin: `pin_oe_o` is high and `pin_o` equals the output register bit.
- R7: A read of the input group returns the synchronised pin sample XOR the polarity bit, per bit.
- R8: After reset, every direction bit is 1 (all pins are inputs), the output register is all ones, the polarity register is all zeros, and SDA is released.
- R9: During a read, the target releases SDA on the host's acknowledge bit. A not-acknowledge ends the read, and SDA stays released until the next start.
- R10: The target changes its drive on SDA, turning it on or changing a data bit, only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | Pull SDA low when high |
| addr_sel_i | input | SEL_W | Low bits of the target address |
| pin_i | input | 16 | Pin samples, port 1 in bits [15:8] |
| pin_o | output | 16 | Output register value per pin |
| pin_oe_o | output | 16 | Driver enable per pin |

## Verification
The bench uses the default parameters: a 7'h20 base with one select bit, and two synchroniser stages. Both address values are therefore reachable, along with a mismatching third address. The bench runs SCL at 40 system clocks per bit. This leaves enough margin for the three-cycle sense latency for every drive change to land inside the low phase, and for the high-phase stability of each read bit to be checked. The scoreboard holds the expected read bytes, which are worked out from the register writes and pin patterns. This exposes errors in the pointer alternation, the polarity XOR and the ignored input-group writes.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    localparam int BYTE_W = 8;
    localparam int NPORT  = 2;
    localparam int NPIN   = BYTE_W * NPORT;

    typedef enum logic [1:0] {
        GRP_IN  = 2'd0,
        GRP_OUT = 2'd1,
        GRP_POL = 2'd2,
        GRP_DIR = 2'd3
    } reg_grp_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_AACK, ST_CMD, ST_CACK,
        ST_WDAT, ST_WACK, ST_RDAT, ST_RACK
    } bus_st_e;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int           W      = 1,
    parameter int           STAGES = 2,
    parameter logic [W-1:0] INIT   = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stage_q[s] <= INIT;
                else         stage_q[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stage_q[s] <= INIT;
                else         stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
    import gpx_pkg::*;
(
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          we_i,
    input  logic [2:0]                    ptr_i,
    input  logic [BYTE_W-1:0]             wdata_i,
    input  logic [NPORT-1:0][BYTE_W-1:0]  pin_s_i,
    output logic [BYTE_W-1:0]             rd_data_o,
    output logic [NPIN-1:0]               pin_o,
    output logic [NPIN-1:0]               pin_oe_o
);
    typedef struct packed {
        logic [NPORT-1:0][BYTE_W-1:0] outv;
        logic [NPORT-1:0][BYTE_W-1:0] pol;
        logic [NPORT-1:0][BYTE_W-1:0] dir;
    } regs_t;

    regs_t regs_d, regs_q;
    reg_grp_e grp;
    logic     port;

    assign grp  = reg_grp_e'(ptr_i[2:1]);
    assign port = ptr_i[0];

    always_comb begin
        regs_d = regs_q;
        if (we_i) begin
            unique case (grp)
                GRP_OUT: regs_d.outv[port] = wdata_i;
                GRP_POL: regs_d.pol[port]  = wdata_i;
                GRP_DIR: regs_d.dir[port]  = wdata_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q.outv <= '1;
            regs_q.pol  <= '0;
            regs_q.dir  <= '1;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        unique case (grp)
            GRP_IN:  rd_data_o = pin_s_i[port] ^ regs_q.pol[port];
            GRP_OUT: rd_data_o = regs_q.outv[port];
            GRP_POL: rd_data_o = regs_q.pol[port];
            default: rd_data_o = regs_q.dir[port];
        endcase
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign pin_o[p*BYTE_W +: BYTE_W]    = regs_q.outv[p];
        assign pin_oe_o[p*BYTE_W +: BYTE_W] = ~regs_q.dir[p];
    end

    assert_in_write_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && ptr_i[2:1] == 2'b00) |=> ($stable(regs_q.outv) && $stable(regs_q.pol) && $stable(regs_q.dir)));

    assert_dir_write_lands_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && ptr_i == 3'd6) |=> (regs_q.dir[0] == $past(wdata_i)));
endmodule

// File: rtl/gpx_i2c_fsm.sv
module gpx_i2c_fsm
    import gpx_pkg::*;
#(
    parameter logic [6:0] ADDR_BASE = 7'h20,
    parameter int         SEL_W     = 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [SEL_W-1:0]  addr_sel_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              sda_oe_o,
    output logic [2:0]        ptr_o,
    output logic              we_o,
    output logic [BYTE_W-1:0] wdata_o
);
    typedef struct packed {
        bus_st_e           st;
        logic [3:0]        cnt;
        logic [BYTE_W-1:0] sh;
        logic [2:0]        ptr;
        logic              rw;
        logic              nack;
        logic [SEL_W-1:0]  sel;
        logic              oe;
        logic              scl_p;
        logic              sda_p;
        logic              we;
        logic [BYTE_W-1:0] wd;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic start_ev, stop_ev, rise_ev, fall_ev, addr_ok;
    logic [2:0] ptr_flip;

    assign start_ev = fsm_q.scl_p & scl_i & fsm_q.sda_p & ~sda_i;
    assign stop_ev  = fsm_q.scl_p & scl_i & ~fsm_q.sda_p & sda_i;
    assign rise_ev  = ~fsm_q.scl_p & scl_i;
    assign fall_ev  = fsm_q.scl_p & ~scl_i;
    assign addr_ok  = (fsm_q.sh[7:1] == {ADDR_BASE[6:SEL_W], fsm_q.sel});
    assign ptr_flip = {fsm_q.ptr[2:1], ~fsm_q.ptr[0]};

    always_comb begin
        fsm_d       = fsm_q;
        fsm_d.we    = 1'b0;
        fsm_d.scl_p = scl_i;
        fsm_d.sda_p = sda_i;
        if (start_ev) begin
            fsm_d.st  = ST_ADDR;
            fsm_d.cnt = '0;
            fsm_d.oe  = 1'b0;
            fsm_d.sel = addr_sel_i;
        end else if (stop_ev) begin
            fsm_d.st = ST_IDLE;
            fsm_d.oe = 1'b0;
        end else begin
            unique case (fsm_q.st)
                ST_ADDR, ST_CMD, ST_WDAT: begin
                    if (rise_ev && fsm_q.cnt < 4'd8) begin
                        fsm_d.sh  = {fsm_q.sh[6:0], sda_i};
                        fsm_d.cnt = fsm_q.cnt + 4'd1;
                    end
                    if (fall_ev && fsm_q.cnt == 4'd8) begin
                        fsm_d.cnt = '0;
                        fsm_d.oe  = 1'b1;
                        if (fsm_q.st == ST_ADDR) begin
                            if (addr_ok) begin
                                fsm_d.st = ST_AACK;
                                fsm_d.rw = fsm_q.sh[0];
                            end else begin
                                fsm_d.st = ST_IDLE;
                                fsm_d.oe = 1'b0;
                            end
                        end else if (fsm_q.st == ST_CMD) begin
                            fsm_d.st  = ST_CACK;
                            fsm_d.ptr = fsm_q.sh[2:0];
                        end else begin
                            fsm_d.st = ST_WACK;
                            fsm_d.we = 1'b1;
                            fsm_d.wd = fsm_q.sh;
                        end
                    end
                end
                ST_AACK, ST_CACK, ST_WACK: begin
                    if (fall_ev) begin
                        fsm_d.oe  = 1'b0;
                        fsm_d.cnt = '0;
                        if (fsm_q.st == ST_AACK && fsm_q.rw) begin
                            fsm_d.st  = ST_RDAT;
                            fsm_d.sh  = rd_data_i;
                            fsm_d.oe  = ~rd_data_i[7];
                            fsm_d.ptr = ptr_flip;
                        end else if (fsm_q.st == ST_AACK) begin
                            fsm_d.st = ST_CMD;
                        end else begin
                            fsm_d.st = ST_WDAT;
                            if (fsm_q.st == ST_WACK) fsm_d.ptr = ptr_flip;
                        end
                    end
                end
                ST_RDAT: begin
                    if (rise_ev) fsm_d.cnt = fsm_q.cnt + 4'd1;
                    if (fall_ev) begin
                        if (fsm_q.cnt == 4'd8) begin
                            fsm_d.oe = 1'b0;
                            fsm_d.st = ST_RACK;
                        end else begin
                            fsm_d.sh = {fsm_q.sh[6:0], 1'b0};
                            fsm_d.oe = ~fsm_q.sh[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (rise_ev) fsm_d.nack = sda_i;
                    if (fall_ev) begin
                        if (fsm_q.nack) begin
                            fsm_d.st = ST_IDLE;
                        end else begin
                            fsm_d.st  = ST_RDAT;
                            fsm_d.cnt = '0;
                            fsm_d.sh  = rd_data_i;
                            fsm_d.oe  = ~rd_data_i[7];
                            fsm_d.ptr = ptr_flip;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fsm_q       <= '0;
            fsm_q.st    <= ST_IDLE;
            fsm_q.scl_p <= 1'b1;
            fsm_q.sda_p <= 1'b1;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign sda_oe_o = fsm_q.oe;
    assign ptr_o    = fsm_q.ptr;
    assign we_o     = fsm_q.we;
    assign wdata_o  = fsm_q.wd;

    assert_drive_in_low_phase_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fsm_q.oe) |-> !$past(scl_i));

    assert_stop_releases_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_q.scl_p && scl_i && !fsm_q.sda_p && sda_i) |=> !fsm_q.oe);

    assert_ack_held_high_phase_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_q.st inside {ST_AACK, ST_CACK, ST_WACK} && fsm_q.scl_p && scl_i) |-> fsm_q.oe);

    assert_master_ack_released_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_q.st == ST_RACK) |-> !fsm_q.oe);
endmodule

// File: rtl/gpx_expander.sv
module gpx_expander
    import gpx_pkg::*;
#(
    parameter logic [6:0] ADDR_BASE   = 7'h20,
    parameter int         SEL_W       = 1,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe_o,
    input  logic [SEL_W-1:0] addr_sel_i,
    input  logic [NPIN-1:0]  pin_i,
    output logic [NPIN-1:0]  pin_o,
    output logic [NPIN-1:0]  pin_oe_o
);
    logic [1:0]        bus_s;
    logic [NPIN-1:0]   pin_s;
    logic [2:0]        ptr;
    logic              we;
    logic [BYTE_W-1:0] wdata, rd_data;

    gpx_sync #(.W(2), .STAGES(SYNC_STAGES), .INIT(2'b11)) i_bus_sync (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i({scl_i, sda_i}), .q_o(bus_s)
    );

    gpx_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .INIT('0)) i_pin_sync (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(pin_s)
    );

    gpx_i2c_fsm #(.ADDR_BASE(ADDR_BASE), .SEL_W(SEL_W)) i_fsm (
        .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(bus_s[1]), .sda_i(bus_s[0]),
        .addr_sel_i(addr_sel_i), .rd_data_i(rd_data), .sda_oe_o(sda_oe_o),
        .ptr_o(ptr), .we_o(we), .wdata_o(wdata)
    );

    gpx_regs i_regs (
        .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we), .ptr_i(ptr), .wdata_i(wdata),
        .pin_s_i(pin_s), .rd_data_o(rd_data), .pin_o(pin_o), .pin_oe_o(pin_oe_o)
    );
endmodule

// File: tb/test_gpx_expander.sv
module test_gpx_expander;
    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        m_low = 1'b0;
    logic        sda_line;
    logic        sda_oe;
    logic [0:0]  addr_sel = 1'b0;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic rd_phase = 1'b0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    assign sda_line = ~(m_low | sda_oe);

    gpx_expander i_gpx_expander (
        .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .addr_sel_i(addr_sel), .pin_i(pin_in),
        .pin_o(pin_out), .pin_oe_o(pin_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic bus_start();
        tick(Q); m_low = 1'b0; tick(Q); scl = 1'b1;
        tick(Q); m_low = 1'b1; tick(Q); scl = 1'b0;
    endtask

    task automatic bus_stop();
        tick(Q); m_low = 1'b1; tick(Q); scl = 1'b1;
        tick(Q); m_low = 1'b0; tick(Q);
    endtask

    task automatic clk_bit(input logic drive_low);
        tick(Q); m_low = drive_low; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, output logic ack);
        logic a0, a1;
        for (int i = 7; i >= 0; i--) clk_bit(~b[i]);
        tick(Q); m_low = 1'b0; tick(Q); scl = 1'b1;
        tick(1); a0 = sda_line; tick(2*Q-2); a1 = sda_line; tick(1); scl = 1'b0;
        ack = (a0 == 1'b0) && (a1 == 1'b0);
    endtask

    task automatic recv(input logic master_ack);
        rd_phase = 1'b1;
        for (int i = 0; i < 8; i++) clk_bit(1'b0);
        rd_phase = 1'b0;
        tick(Q); m_low = master_ack; tick(Q); scl = 1'b1;
        tick(1); chk("R9 released on host ack bit", {31'd0, sda_oe}, 32'd0);
        tick(2*Q-1); scl = 1'b0;
    endtask

    // scoreboard monitor: assembles read bytes from the line, compares with queue
    logic [7:0] mon_sh = '0;
    int mon_n = 0;
    logic mon_b0;
    initial forever begin
        @(posedge scl);
        if (rd_phase) begin
            tick(1); mon_b0 = sda_line; tick(2*Q-3);
            chk("R10 read bit stable while SCL high", {31'd0, sda_line}, {31'd0, mon_b0});
            mon_sh = {mon_sh[6:0], mon_b0};
            mon_n++;
            if (mon_n == 8) begin
                mon_n = 0;
                if (exp_q.size() == 0) chk("R7 unexpected read byte", 32'd1, 32'd0);
                else chk("R4/R7 read byte", {24'd0, mon_sh}, {24'd0, exp_q.pop_front()});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired (R1 bus hang)");
        finish_run();
    end

    initial begin
        logic ack;
        tick(5); rst_n = 1'b1; tick(5);

        // R8 reset state
        chk("R8 oe after reset", {16'd0, pin_oe}, 32'h0000);
        chk("R8 out after reset", {16'd0, pin_out}, 32'hFFFF);
        chk("R8 sda released", {31'd0, sda_oe}, 32'd0);

        // direction write, pointer flips port
        bus_start();
        send(8'h40, ack); chk("R2 address ack", {31'd0, ack}, 32'd1);
        send(8'h06, ack); chk("R4 command ack", {31'd0, ack}, 32'd1);
        send(8'h0F, ack); chk("R4 data ack", {31'd0, ack}, 32'd1);
        send(8'hF0, ack);
        bus_stop();
        chk("R1 sda released after stop", {31'd0, sda_oe}, 32'd0);
        chk("R6 oe follows direction", {16'd0, pin_oe}, 32'h0FF0);

        // output register
        bus_start(); send(8'h40, ack); send(8'h02, ack); send(8'h5A, ack); send(8'hC3, ack); bus_stop();
        chk("R6 pin_o equals output register", {16'd0, pin_out}, 32'hC35A);

        // polarity register
        bus_start(); send(8'h40, ack); send(8'h04, ack); send(8'hFF, ack); send(8'h00, ack); bus_stop();

        // input read with polarity, repeated start
        pin_in = 16'h1234;
        bus_start(); send(8'h40, ack); send(8'h00, ack);
        bus_start(); send(8'h41, ack); chk("R2 read address ack", {31'd0, ack}, 32'd1);
        exp_q.push_back(8'hCB); exp_q.push_back(8'h12);
        recv(1'b1); recv(1'b0);
        for (int i = 0; i < 2; i++) begin
            tick(Q); tick(Q); scl = 1'b1; tick(Q);
            chk("R9 released after host nack", {31'd0, sda_oe}, 32'd0);
            tick(Q); scl = 1'b0;
        end
        bus_stop();

        // read direction starting at port 1, pointer wraps to port 0
        bus_start(); send(8'h40, ack); send(8'h07, ack);
        bus_start(); send(8'h41, ack);
        exp_q.push_back(8'hF0); exp_q.push_back(8'h0F);
        recv(1'b1); recv(1'b0); bus_stop();

        // writes to input group ignored
        bus_start(); send(8'h40, ack); send(8'h00, ack); send(8'h00, ack); send(8'h00, ack); bus_stop();
        chk("R5 out unchanged", {16'd0, pin_out}, 32'hC35A);
        chk("R5 oe unchanged", {16'd0, pin_oe}, 32'h0FF0);
        bus_start(); send(8'h40, ack); send(8'h04, ack);
        bus_start(); send(8'h41, ack);
        exp_q.push_back(8'hFF); exp_q.push_back(8'h00);
        recv(1'b1); recv(1'b0); bus_stop();

        // mismatched address
        bus_start(); send(8'h44, ack); chk("R2 no ack on mismatch", {31'd0, ack}, 32'd0);
        send(8'h02, ack); chk("R2 bytes ignored after mismatch", {31'd0, ack}, 32'd0);
        send(8'h00, ack); bus_stop();
        chk("R2 out unchanged after mismatch", {16'd0, pin_out}, 32'hC35A);

        // select captured at start
        addr_sel = 1'b1;
        bus_start(); addr_sel = 1'b0;
        send(8'h42, ack); chk("R3 select latched at start", {31'd0, ack}, 32'd1);
        send(8'h02, ack); send(8'h00, ack); bus_stop();
        chk("R3 write under alternate address", {16'd0, pin_out}, 32'hC300);
        bus_start(); send(8'h42, ack); chk("R3 old select no longer matches", {31'd0, ack}, 32'd0);
        bus_stop();

        // start partway through a byte restarts reception
        bus_start(); clk_bit(1'b0); clk_bit(1'b1); clk_bit(1'b0);
        bus_start(); send(8'h40, ack); chk("R1 restart mid-byte ack", {31'd0, ack}, 32'd1);
        send(8'h03, ack); send(8'h77, ack); bus_stop();
        chk("R1 write after restart", {16'd0, pin_out}, 32'h7700);

        chk("R7 scoreboard drained", exp_q.size(), 32'd0);
        finish_run();
    end
endmodule